// File: doc/BRIEF.md
# Wiper Quick-Command Arithmetic Unit

This block holds four wiper position registers and carries out the arithmetic quick commands on them. A bus decoder hands it a 4-bit opcode, a channel index and a one-cycle strobe. The arithmetic opcodes are:

- a linear step up by one;
- a linear step down by one;
- a doubling (+6 dB, a left shift);
- a halving (-6 dB, a right shift).

Each of these exists in a one-channel form and an all-channel form. Results clamp at zero and at full scale, so they never wrap. The registers change at the clock edge that samples the strobe.

Opcodes that concern the nonvolatile store are not acted on here. These are NOP, restore one channel, store one channel and restore all. They are handed on, registered, to the nonvolatile sequencer. Reserved opcodes do nothing to the wipers and raise a one-cycle illegal-command flag.

Two load ports complete the datapath:

- A bus write port, which write protect blocks.
- A restore load port, through which the sequencer returns stored values. Write protect does not block it.

The wiper width is a parameter of 8 or 6 bits. When it is 6, the upper bits of incoming data are dropped.

Top module: `wiper_qcmd_unit`

## Requirements
- R1: After reset every wiper holds midscale (bit WIPER_W-1 set, all others clear: 128 for 8 bits, 32 for 6 bits). After reset `fwd_valid` and `illegal_cmd` are low.
- R2: Opcode 10 adds one to the wiper of channel `cmd_chan`, and opcode 11 adds one to all four wipers. A wiper already at full scale (all ones) stays at full scale.
- R3: Opcode 5 subtracts one from the wiper of channel `cmd_chan`, and opcode 6 subtracts one from all four wipers. A wiper at zero stays at zero.
- R4: Opcode 8 doubles the wiper of channel `cmd_chan`, and opcode 9 doubles all four wipers. Doubling maps 0 to 1 and maps any value whose double exceeds full scale to full scale. Nine doublings take an 8-bit wiper from 0 to 255.
- R5: Opcode 3 halves the wiper of channel `cmd_chan`, and opcode 4 halves all four wipers, by a right shift with zero fill. Eight halvings take an 8-bit wiper from 255 to 0.
- R6: An all-channel opcode updates all four wipers at the same clock edge. A one-channel opcode changes only the wiper selected by `cmd_chan`.
- R7: A strobe with opcode 0, 1, 2 or 7 leaves the wipers unchanged. One cycle later it produces `fwd_valid` high, with `fwd_op` and `fwd_chan` equal to the strobed opcode and channel.
- R8: A strobe with an opcode from 12 to 15 leaves the wipers unchanged. One cycle later `illegal_cmd` is high for one cycle and `fwd_valid` is low.
- R9: While `wp_active` is high, the following are suppressed:
  - arithmetic opcodes, which leave the wipers unchanged;
  - bus writes, which leave the wipers unchanged;
  - opcode 2, which is not forwarded.

  Opcodes 0, 1 and 7 are still forwarded while `wp_active` is high.
- R10: A bus write (`wr_valid`) or a restore load (`ld_valid`) sets the selected wiper to the low WIPER_W bits of its data at the next edge. With 6-bit wipers, data bits 7:6 are ignored. Restore loads take effect even while `wp_active` is high.
- R11: When several sources target one channel in the same cycle, the restore load wins over the bus write, and the bus write wins over the arithmetic opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Quick-command strobe from the bus decoder |
| cmd_op | input | 4 | Quick-command opcode |
| cmd_chan | input | CH_W (2) | Target channel for one-channel opcodes |
| wp_active | input | 1 | Write protect level |
| wr_valid | input | 1 | Bus write strobe |
| wr_chan | input | CH_W (2) | Bus write channel |
| wr_data | input | DATA_W (8) | Bus write data |
| ld_valid | input | 1 | Restore load strobe from the nonvolatile sequencer |
| ld_chan | input | CH_W (2) | Restore load channel |
| ld_data | input | DATA_W (8) | Restored wiper value |
| wiper_q | output | NUM_CH*WIPER_W (32) | Wiper registers, channel 0 in the low bits |
| fwd_valid | output | 1 | Forwarded opcode valid, one cycle after the strobe |
| fwd_op | output | 4 | Forwarded opcode |
| fwd_chan | output | CH_W (2) | Forwarded channel |
| illegal_cmd | output | 1 | One-cycle flag for a reserved opcode |

## Verification
The bench targets the saturation edges, where a careless design would wrap:

- an increment of 255 that returns 0;
- a decrement of 0 that returns 255;
- a doubling of 128 that returns 0;
- a doubling of 0 that sticks at 0, so that full scale is never reached in nine steps.

It also targets the decode edges. A design that got these wrong would:

- touch only one channel on an all-channel opcode, or touch all channels on a one-channel opcode;
- forward a store while write protect is on;
- drop a restore under write protect;
- let a bus write beat a same-cycle restore.

A second instance with 6-bit wipers catches data bits 7:6 leaking into the register. It also catches the clamp points being left at their 8-bit values.

// File: rtl/wqc_pkg.sv
package wqc_pkg;

  typedef enum logic [3:0] {
    OP_NOP         = 4'd0,
    OP_RESTORE_ONE = 4'd1,
    OP_STORE_ONE   = 4'd2,
    OP_HALVE_ONE   = 4'd3,
    OP_HALVE_ALL   = 4'd4,
    OP_DEC_ONE     = 4'd5,
    OP_DEC_ALL     = 4'd6,
    OP_RESTORE_ALL = 4'd7,
    OP_DOUBLE_ONE  = 4'd8,
    OP_DOUBLE_ALL  = 4'd9,
    OP_INC_ONE     = 4'd10,
    OP_INC_ALL     = 4'd11
  } qcmd_op_e;

  typedef enum logic [2:0] {
    ARITH_NONE = 3'd0,
    ARITH_INC  = 3'd1,
    ARITH_DEC  = 3'd2,
    ARITH_DBL  = 3'd3,
    ARITH_HLV  = 3'd4
  } arith_e;

  typedef struct packed {
    arith_e kind;      // arithmetic action, NONE for non-arithmetic opcodes
    logic   all_ch;    // applies to every channel
    logic   fwd;       // handed to the nonvolatile sequencer
    logic   fwd_wp_ok; // still forwarded under write protect
    logic   illegal;   // reserved opcode
  } qcmd_dec_t;

endpackage

// File: rtl/wqc_decode.sv
module wqc_decode
  import wqc_pkg::*;
(
  input  logic [3:0] op,
  output qcmd_dec_t  dec
);

  always_comb begin
    dec           = '0;
    dec.kind      = ARITH_NONE;
    case (op)
      OP_NOP:         begin dec.fwd = 1'b1; dec.fwd_wp_ok = 1'b1; end
      OP_RESTORE_ONE: begin dec.fwd = 1'b1; dec.fwd_wp_ok = 1'b1; end
      OP_STORE_ONE:   begin dec.fwd = 1'b1; dec.fwd_wp_ok = 1'b0; end
      OP_RESTORE_ALL: begin dec.fwd = 1'b1; dec.fwd_wp_ok = 1'b1; end
      OP_HALVE_ONE:   dec.kind = ARITH_HLV;
      OP_HALVE_ALL:   begin dec.kind = ARITH_HLV; dec.all_ch = 1'b1; end
      OP_DEC_ONE:     dec.kind = ARITH_DEC;
      OP_DEC_ALL:     begin dec.kind = ARITH_DEC; dec.all_ch = 1'b1; end
      OP_DOUBLE_ONE:  dec.kind = ARITH_DBL;
      OP_DOUBLE_ALL:  begin dec.kind = ARITH_DBL; dec.all_ch = 1'b1; end
      OP_INC_ONE:     dec.kind = ARITH_INC;
      OP_INC_ALL:     begin dec.kind = ARITH_INC; dec.all_ch = 1'b1; end
      default:        dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/wqc_lane.sv
module wqc_lane
  import wqc_pkg::*;
#(
  parameter int WIPER_W = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  arith_e             kind,
  input  logic               wr_hit,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ld_hit,
  input  logic [DATA_W-1:0]  ld_data,
  output logic [WIPER_W-1:0] wiper
);

  localparam logic [WIPER_W-1:0] FULL = '1;
  localparam logic [WIPER_W-1:0] ZERO = '0;
  localparam logic [WIPER_W-1:0] MID  = {1'b1, {(WIPER_W-1){1'b0}}};
  localparam logic [WIPER_W-1:0] ONE  = {{(WIPER_W-1){1'b0}}, 1'b1};

  function automatic logic [WIPER_W-1:0] f_inc(input logic [WIPER_W-1:0] v);
    return (v == FULL) ? FULL : v + ONE;
  endfunction

  function automatic logic [WIPER_W-1:0] f_dec(input logic [WIPER_W-1:0] v);
    return (v == ZERO) ? ZERO : v - ONE;
  endfunction

  function automatic logic [WIPER_W-1:0] f_dbl(input logic [WIPER_W-1:0] v);
    if (v == ZERO)       return ONE;
    if (v[WIPER_W-1])    return FULL;
    return {v[WIPER_W-2:0], 1'b0};
  endfunction

  function automatic logic [WIPER_W-1:0] f_hlv(input logic [WIPER_W-1:0] v);
    return {1'b0, v[WIPER_W-1:1]};
  endfunction

  // Named internal events used by the assertions
  logic               cmd_effective;
  logic [WIPER_W-1:0] arith_res;
  logic [WIPER_W-1:0] nxt;

  assign cmd_effective = apply && (kind != ARITH_NONE) && !wr_hit && !ld_hit;

  always_comb begin
    case (kind)
      ARITH_INC: arith_res = f_inc(wiper);
      ARITH_DEC: arith_res = f_dec(wiper);
      ARITH_DBL: arith_res = f_dbl(wiper);
      ARITH_HLV: arith_res = f_hlv(wiper);
      default:   arith_res = wiper;
    endcase
  end

  always_comb begin
    nxt = wiper;
    if (apply)  nxt = arith_res;
    if (wr_hit) nxt = wr_data[WIPER_W-1:0];
    if (ld_hit) nxt = ld_data[WIPER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper <= MID;
    else        wiper <= nxt;
  end

  // R2: stepping up from full scale stays at full scale
  assert_inc_ceiling_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && kind == ARITH_INC && wiper == FULL) |=> wiper == FULL);

  // R3: stepping down from zero stays at zero
  assert_dec_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && kind == ARITH_DEC && wiper == ZERO) |=> wiper == ZERO);

  // R4: doubling zero yields one, doubling never lowers the value
  assert_dbl_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && kind == ARITH_DBL && wiper == ZERO) |=> wiper == ONE);
  assert_dbl_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && kind == ARITH_DBL) |=> wiper >= $past(wiper));

  // R5: halving is a right shift of the previous value
  assert_halve_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_effective && kind == ARITH_HLV) |=> wiper == ($past(wiper) >> 1));

  // R11: a restore load beats every other source on this channel
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |=> wiper == $past(ld_data[WIPER_W-1:0]));

endmodule

// File: rtl/wiper_qcmd_unit.sv
module wiper_qcmd_unit
  import wqc_pkg::*;
#(
  parameter int  WIPER_W = 8,
  parameter int  NUM_CH  = 4,
  parameter int  DATA_W  = 8,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [3:0]                cmd_op,
  input  logic [CH_W-1:0]           cmd_chan,
  input  logic                      wp_active,
  input  logic                      wr_valid,
  input  logic [CH_W-1:0]           wr_chan,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      ld_valid,
  input  logic [CH_W-1:0]           ld_chan,
  input  logic [DATA_W-1:0]         ld_data,
  output logic [NUM_CH*WIPER_W-1:0] wiper_q,
  output logic                      fwd_valid,
  output logic [3:0]                fwd_op,
  output logic [CH_W-1:0]           fwd_chan,
  output logic                      illegal_cmd
);

  qcmd_dec_t dec;

  wqc_decode u_decode (
    .op  (cmd_op),
    .dec (dec)
  );

  // Named internal events
  logic arith_req;    // strobe carries an arithmetic opcode
  logic arith_go;     // arithmetic opcode allowed through write protect
  logic wp_blocked;   // arithmetic opcode swallowed by write protect
  logic wr_go;        // bus write allowed through write protect
  logic fwd_go;       // opcode handed to the sequencer this cycle

  assign arith_req  = cmd_valid && (dec.kind != ARITH_NONE);
  assign arith_go   = arith_req && !wp_active;
  assign wp_blocked = arith_req && wp_active;
  assign wr_go      = wr_valid && !wp_active;
  assign fwd_go     = cmd_valid && dec.fwd && (!wp_active || dec.fwd_wp_ok);

  logic [WIPER_W-1:0] lane_q [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic sel_cmd, sel_wr, sel_ld;
    assign sel_cmd = arith_go && (dec.all_ch || (cmd_chan == CH_W'(ch)));
    assign sel_wr  = wr_go    && (wr_chan == CH_W'(ch));
    assign sel_ld  = ld_valid && (ld_chan == CH_W'(ch));

    wqc_lane #(
      .WIPER_W (WIPER_W),
      .DATA_W  (DATA_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply   (sel_cmd),
      .kind    (dec.kind),
      .wr_hit  (sel_wr),
      .wr_data (wr_data),
      .ld_hit  (sel_ld),
      .ld_data (ld_data),
      .wiper   (lane_q[ch])
    );

    assign wiper_q[ch*WIPER_W +: WIPER_W] = lane_q[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid   <= 1'b0;
      fwd_op      <= '0;
      fwd_chan    <= '0;
      illegal_cmd <= 1'b0;
    end else begin
      fwd_valid   <= fwd_go;
      illegal_cmd <= cmd_valid && dec.illegal;
      if (fwd_go) begin
        fwd_op   <= cmd_op;
        fwd_chan <= cmd_chan;
      end
    end
  end

  // R9: write protect without a restore load freezes every wiper
  assert_wp_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_active && !ld_valid) |=> $stable(wiper_q));

  // R9: a store request under write protect is not forwarded
  assert_wp_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && wp_active && cmd_op == 4'd2) |=> !fwd_valid);

  // R7: restore opcodes always reach the sequencer, with their channel
  assert_restore_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd7)) |=>
      (fwd_valid && fwd_op == $past(cmd_op) && fwd_chan == $past(cmd_chan)));

  // R8: reserved opcodes flag and leave the wipers alone
  assert_reserved_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 4'd12 && !ld_valid && !wr_go) |=>
      (illegal_cmd && !fwd_valid && $stable(wiper_q)));

  // R8: the illegal flag lasts one cycle for a single strobe
  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_cmd && !cmd_valid) |=> !illegal_cmd);

  // R9: a blocked arithmetic request never shows up as a wiper change
  assert_blocked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_blocked && !ld_valid) |=> $stable(wiper_q));

endmodule

// File: tb/wiper_qcmd_unit_tb_top.sv
module wiper_qcmd_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [1:0] cmd_chan = '0;
  logic       wp_active = 1'b0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_chan = '0;
  logic [7:0] wr_data = '0;
  logic       ld_valid = 1'b0;
  logic [1:0] ld_chan = '0;
  logic [7:0] ld_data = '0;

  logic [31:0] wq8;
  logic [23:0] wq6;
  logic        fv8, fv6, il8, il6;
  logic [3:0]  fo8, fo6;
  logic [1:0]  fc8, fc6;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_qcmd_unit #(.WIPER_W(8), .NUM_CH(NCH), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .wp_active(wp_active), .wr_valid(wr_valid),
    .wr_chan(wr_chan), .wr_data(wr_data), .ld_valid(ld_valid),
    .ld_chan(ld_chan), .ld_data(ld_data), .wiper_q(wq8), .fwd_valid(fv8),
    .fwd_op(fo8), .fwd_chan(fc8), .illegal_cmd(il8));

  wiper_qcmd_unit #(.WIPER_W(6), .NUM_CH(NCH), .DATA_W(8)) dut6_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .wp_active(wp_active), .wr_valid(wr_valid),
    .wr_chan(wr_chan), .wr_data(wr_data), .ld_valid(ld_valid),
    .ld_chan(ld_chan), .ld_data(ld_data), .wiper_q(wq6), .fwd_valid(fv6),
    .fwd_op(fo6), .fwd_chan(fc6), .illegal_cmd(il6));

  // ---------------- behavioural reference model ----------------
  int m8 [NCH];
  int m6 [NCH];
  int e_fv, e_fo, e_fc, e_il;
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit started = 0;
  bit finished = 0;
  string cur_req = "R1";

  function automatic int ref_step(int v, int op, int fs);
    case (op)
      3, 4:   return v / 2;
      5, 6:   return (v == 0) ? 0 : v - 1;
      8, 9:   begin
                if (v == 0) return 1;
                if (v * 2 > fs) return fs;
                return v * 2;
              end
      10, 11: return (v == fs) ? fs : v + 1;
      default: return v;
    endcase
  endfunction

  function automatic bit is_arith(int op);
    return (op >= 3 && op <= 6) || (op >= 8 && op <= 11);
  endfunction

  function automatic bit is_all(int op);
    return op == 4 || op == 6 || op == 9 || op == 11;
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++) begin m8[c] = 128; m6[c] = 32; end
    e_fv = 0; e_fo = 0; e_fc = 0; e_il = 0;
  end

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m8[c] = 128; m6[c] = 32; end
      e_fv = 0; e_fo = 0; e_fc = 0; e_il = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cmd_valid && !wp_active && is_arith(cmd_op) &&
            (is_all(cmd_op) || cmd_chan == c)) begin
          m8[c] = ref_step(m8[c], cmd_op, 255);
          m6[c] = ref_step(m6[c], cmd_op, 63);
        end
        if (wr_valid && !wp_active && wr_chan == c) begin
          m8[c] = wr_data;
          m6[c] = wr_data % 64;
        end
        if (ld_valid && ld_chan == c) begin
          m8[c] = ld_data;
          m6[c] = ld_data % 64;
        end
      end
      e_il = (cmd_valid && cmd_op >= 12) ? 1 : 0;
      if (cmd_valid && (cmd_op == 0 || cmd_op == 1 || cmd_op == 7 ||
                        (cmd_op == 2 && !wp_active))) begin
        e_fv = 1; e_fo = cmd_op; e_fc = cmd_chan;
      end else begin
        e_fv = 0;
      end
    end
  end

  task automatic miss(string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      for (int c = 0; c < NCH; c++) begin
        if (int'(wq8[c*8 +: 8]) != m8[c]) miss($sformatf("wiper8[%0d]", c), int'(wq8[c*8 +: 8]), m8[c]);
        if (int'(wq6[c*6 +: 6]) != m6[c]) miss($sformatf("wiper6[%0d]", c), int'(wq6[c*6 +: 6]), m6[c]);
      end
      if (int'(fv8) != e_fv) miss("fwd_valid", int'(fv8), e_fv);
      if (int'(fv6) != e_fv) miss("fwd_valid6", int'(fv6), e_fv);
      if (int'(il8) != e_il) miss("illegal_cmd", int'(il8), e_il);
      if (int'(il6) != e_il) miss("illegal_cmd6", int'(il6), e_il);
      if (e_fv == 1) begin
        if (int'(fo8) != e_fo) miss("fwd_op", int'(fo8), e_fo);
        if (int'(fc8) != e_fc) miss("fwd_chan", int'(fc8), e_fc);
        if (int'(fo6) != e_fo) miss("fwd_op6", int'(fo6), e_fo);
        if (int'(fc6) != e_fc) miss("fwd_chan6", int'(fc6), e_fc);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_valid  = 1'b0;
    ld_valid  = 1'b0;
  endtask

  task automatic qcmd(int op, int ch);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_chan = 2'(ch);
    tick();
  endtask

  task automatic bus_wr(int ch, int d);
    wr_valid = 1'b1; wr_chan = 2'(ch); wr_data = 8'(d);
    tick();
  endtask

  task automatic nv_ld(int ch, int d);
    ld_valid = 1'b1; ld_chan = 2'(ch); ld_data = 8'(d);
    tick();
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();

    // R10: bus writes, 6-bit copy drops bits 7:6
    cur_req = "R10";
    bus_wr(0, 8'hFF); bus_wr(1, 8'h00); bus_wr(2, 8'hC5); bus_wr(3, 8'h40);
    tick();

    // R2: increment, ceiling at full scale
    cur_req = "R2";
    qcmd(10, 0); qcmd(10, 1); qcmd(11, 0); tick();

    // R3: decrement, floor at zero
    cur_req = "R3";
    bus_wr(1, 0);
    qcmd(5, 1); qcmd(5, 3); qcmd(6, 0); qcmd(6, 0); tick();

    // R4: doubling, nine steps 0 -> full scale, 128 -> 255
    cur_req = "R4";
    bus_wr(2, 0); bus_wr(3, 128);
    for (int k = 0; k < 9; k++) qcmd(8, 2);
    qcmd(8, 3); qcmd(9, 0); tick();

    // R5: halving, eight steps full scale -> 0
    cur_req = "R5";
    bus_wr(0, 255);
    for (int k = 0; k < 8; k++) qcmd(3, 0);
    qcmd(4, 0); qcmd(4, 0); tick();

    // R6: all-channel vs one-channel scope
    cur_req = "R6";
    bus_wr(0, 10); bus_wr(1, 20); bus_wr(2, 30); bus_wr(3, 40);
    qcmd(11, 2); qcmd(10, 2); qcmd(6, 1); qcmd(9, 3); tick();

    // R7: forwarded opcodes
    cur_req = "R7";
    qcmd(0, 3); qcmd(1, 1); qcmd(2, 2); qcmd(7, 0); tick();

    // R8: reserved opcodes
    cur_req = "R8";
    for (int op = 12; op < 16; op++) qcmd(op, op % 4);
    tick();

    // R9: write protect
    cur_req = "R9";
    wp_active = 1'b1;
    qcmd(11, 0); qcmd(8, 1); bus_wr(2, 99); qcmd(2, 1);
    qcmd(1, 2); qcmd(7, 0); qcmd(0, 1); qcmd(4, 0);
    cur_req = "R10";
    nv_ld(3, 200); nv_ld(1, 8'hAB);
    wp_active = 1'b0;
    tick();

    // R11: priority on a shared channel
    cur_req = "R11";
    cmd_valid = 1'b1; cmd_op = 4'd10; cmd_chan = 2'd1;
    wr_valid = 1'b1; wr_chan = 2'd1; wr_data = 8'd50;
    ld_valid = 1'b1; ld_chan = 2'd1; ld_data = 8'd77;
    tick();
    cmd_valid = 1'b1; cmd_op = 4'd11; cmd_chan = 2'd0;
    wr_valid = 1'b1; wr_chan = 2'd2; wr_data = 8'd5;
    tick();
    tick();

    // R6: mixed traffic
    cur_req = "R6";
    for (int k = 0; k < 400; k++) begin
      cmd_valid = ($urandom_range(0, 3) != 0);
      cmd_op    = 4'($urandom_range(0, 15));
      cmd_chan  = 2'($urandom_range(0, 3));
      wr_valid  = ($urandom_range(0, 7) == 0);
      wr_chan   = 2'($urandom_range(0, 3));
      wr_data   = 8'($urandom_range(0, 255));
      ld_valid  = ($urandom_range(0, 9) == 0);
      ld_chan   = 2'($urandom_range(0, 3));
      ld_data   = 8'($urandom_range(0, 255));
      wp_active = ($urandom_range(0, 5) == 0);
      tick();
    end
    wp_active = 1'b0;
    tick(); tick();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule